// File: doc/BRIEF.md
# Paged Indirect Effective-Address Unit

This block resolves the memory address that an instruction of a small 8-bit processor refers to. The processor has a 15-bit address space split into four pages of 8 KB. The unit receives a 16-bit address field from the instruction, a class bit that marks the instruction as a data access or an absolute branch, the current value of the selected index register and the current 2-bit page. It returns a 15-bit effective address with a one-cycle completion strobe. Alongside the address it returns an optional write-back value for the index register and an optional new page value.

The top bit of the address field asks for one level of indirection. In that case the unit reads a two-byte pointer through a simple request/acknowledge memory port and uses the pointer in place of the field. For data accesses, two field bits choose how the index register takes part: not at all, incremented first, decremented first, or added unchanged. The index is always added after any pointer fetch, and the addition wraps inside an 8 KB page. Absolute branches take all 15 bits as the target. They are the only operations that report a new page.

Top module: `paged_ea_unit`

## Requirements
- R1: After reset, busy, eaValid, memReq, idxWrEn and pageWrEn are all 0 and eaOut is 0.
- R2: A direct data access (field bit 15 = 0, isBranch = 0) yields eaOut = {pageIn, (field[12:0] + k) mod 8192}, where k is the zero-extended adjusted index of R3, or 0 when the mode is 00.
- R3: For data accesses, field[14:13] selects the index mode: 00 no index, 01 index+1 then use, 10 index-1 then use (both mod 256), 11 index used unchanged. Modes 01 and 10 raise idxWrEn together with eaValid, with idxWrData equal to the adjusted index. Modes 00 and 11 leave idxWrEn at 0.
- R4: A direct absolute branch (isBranch = 1, field bit 15 = 0) yields eaOut = field[14:0], raises pageWrEn with eaValid and sets pageWrData = field[14:13]. The index value has no effect and idxWrEn stays 0.
- R5: A data access never raises pageWrEn.
- R6: With field bit 15 = 1, the unit makes exactly two reads. The first, the high byte, is at the pointer location. The second, the low byte, is at that location + 1 mod 32768. The pointer location is {pageIn, field[12:0]} for data and field[14:0] for branches. memReq stays high, with memAddr stable, until memAck is seen on a clock edge.
- R7: The pointer is {high[6:0], low}, so the top bit of the high byte is ignored. An indirect branch yields eaOut = pointer and pageWrData = pointer[14:13]. An indirect data access yields {pointer[14:13], (pointer[12:0] + k) mod 8192}.
- R8: startReq is accepted only when busy is 0. The operands are captured in that cycle. A direct operation raises eaValid for exactly one cycle, two clock edges after acceptance. busy is high from the cycle after acceptance through the eaValid cycle. startReq and operand changes while busy have no effect on the result.
- R9: memReq is never high while busy is low, and a direct operation makes no memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to resolve one address |
| addrField | input | 16 | Instruction address field; bit 15 requests indirection |
| isBranch | input | 1 | 1 = absolute branch, 0 = data access |
| idxIn | input | 8 | Value of the index register named by the instruction |
| pageIn | input | 2 | Current page register |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Pointer byte read request |
| memAddr | output | 15 | Pointer byte read address |
| memAck | input | 1 | Read data valid, sampled on the clock edge |
| memData | input | 8 | Read data |
| eaValid | output | 1 | One-cycle completion strobe |
| eaOut | output | 15 | Effective address, held until the next completion |
| idxWrEn | output | 1 | Index register write-back enable, with eaValid |
| idxWrData | output | 8 | Index register write-back value |
| pageWrEn | output | 1 | Page register update enable, with eaValid |
| pageWrData | output | 2 | New page value |

## Verification
The hardest case to reach from the ports is an indirect access whose two pointer bytes lie on either side of the top of the address space. This case also needs a high byte with its unused top bit set and a post-index addition that carries out of the page offset. Directed operations build each of these from chosen field, page and index values. The bench memory returns a byte computed from the address, so the expected pointer is known in advance. Random operations vary the acknowledge delay on every cycle. During one indirect operation, startReq stays high and the operands change, to show that the captured values alone decide the result.

// File: rtl/peau_pkg.sv
package peau_pkg;

  typedef enum logic [1:0] {
    IDX_NONE  = 2'b00,
    IDX_INC   = 2'b01,
    IDX_DEC   = 2'b10,
    IDX_PLAIN = 2'b11
  } idxMode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RDHI = 3'd1,
    ST_RDLO = 3'd2,
    ST_FIN  = 3'd3,
    ST_DONE = 3'd4
  } eaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;   // capture operands
    logic loadHi;   // capture pointer high byte
    logic loadLo;   // capture pointer low byte
    logic selLo;    // address the low pointer byte
    logic finish;   // register the results
  } eaStrobe_t;

endpackage

// File: rtl/peau_idxadj.sv
module peau_idxadj
  import peau_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 13
) (
  input  idxMode_e            mode,
  input  logic [DATA_W-1:0]   idxVal,
  output logic [DATA_W-1:0]   adjIdx,
  output logic [OFS_W-1:0]    addVal,
  output logic                writeBack
);

  always_comb begin
    adjIdx    = idxVal;
    writeBack = 1'b0;
    case (mode)
      IDX_INC: begin
        adjIdx    = idxVal + DATA_W'(1);
        writeBack = 1'b1;
      end
      IDX_DEC: begin
        adjIdx    = idxVal - DATA_W'(1);
        writeBack = 1'b1;
      end
      default: adjIdx = idxVal;
    endcase
    addVal = (mode == IDX_NONE) ? '0 : OFS_W'(adjIdx);
  end

endmodule

// File: rtl/peau_ctrl.sv
module peau_ctrl
  import peau_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      wantIndirect,
  input  logic      memAck,
  output eaStrobe_t stb,
  output logic      memReq,
  output logic      busy,
  output logic      eaValid
);

  eaState_e stateQ, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt = stateQ;
    stb      = '0;
    case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          stb.loadOp = 1'b1;
          stateNxt   = wantIndirect ? ST_RDHI : ST_FIN;
        end
      end
      ST_RDHI: begin
        if (memAck) begin
          stb.loadHi = 1'b1;
          stateNxt   = ST_RDLO;
        end
      end
      ST_RDLO: begin
        stb.selLo = 1'b1;
        if (memAck) begin
          stb.loadLo = 1'b1;
          stateNxt   = ST_FIN;
        end
      end
      ST_FIN: begin
        stb.finish = 1'b1;
        stateNxt   = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign memReq  = (stateQ == ST_RDHI) || (stateQ == ST_RDLO);
  assign busy    = (stateQ != ST_IDLE);
  assign eaValid = (stateQ == ST_DONE);

endmodule

// File: rtl/peau_dpath.sv
module peau_dpath
  import peau_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 13,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  eaStrobe_t           stb,
  input  logic [ADDR_W:0]     addrField,
  input  logic                isBranch,
  input  logic [DATA_W-1:0]   idxIn,
  input  logic [ADDR_W-OFS_W-1:0] pageIn,
  input  logic [DATA_W-1:0]   memData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   eaOut,
  output logic                idxWrEn,
  output logic [DATA_W-1:0]   idxWrData,
  output logic                pageWrEn,
  output logic [ADDR_W-OFS_W-1:0] pageWrData
);

  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int HI_W   = ADDR_W - DATA_W;

  logic               branchQ, indQ, wbQ;
  logic [ADDR_W-1:0]  fieldQ;
  logic [PAGE_W-1:0]  pageQ;
  logic [DATA_W-1:0]  adjQ;
  logic [OFS_W-1:0]   addQ;
  logic [HI_W-1:0]    hiQ;
  logic [DATA_W-1:0]  loQ;

  idxMode_e           modeIn;
  logic [DATA_W-1:0]  adjIdx;
  logic [OFS_W-1:0]   addVal;
  logic               writeBack;

  assign modeIn = idxMode_e'(addrField[OFS_W +: 2]);

  peau_idxadj #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_idxadj (
    .mode      (modeIn),
    .idxVal    (idxIn),
    .adjIdx    (adjIdx),
    .addVal    (addVal),
    .writeBack (writeBack)
  );

  // operand capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      branchQ <= 1'b0;
      indQ    <= 1'b0;
      wbQ     <= 1'b0;
      fieldQ  <= '0;
      pageQ   <= '0;
      adjQ    <= '0;
      addQ    <= '0;
    end else if (stb.loadOp) begin
      branchQ <= isBranch;
      indQ    <= addrField[ADDR_W];
      wbQ     <= writeBack && !isBranch;
      fieldQ  <= addrField[ADDR_W-1:0];
      pageQ   <= pageIn;
      adjQ    <= adjIdx;
      addQ    <= isBranch ? '0 : addVal;
    end
  end

  // pointer capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else begin
      if (stb.loadHi) hiQ <= memData[HI_W-1:0];
      if (stb.loadLo) loQ <= memData;
    end
  end

  logic [ADDR_W-1:0] locAddr, baseAddr, eaNext;

  always_comb begin
    locAddr  = branchQ ? fieldQ : {pageQ, fieldQ[OFS_W-1:0]};
    memAddr  = stb.selLo ? locAddr + ADDR_W'(1) : locAddr;
    baseAddr = indQ ? {hiQ, loQ} : locAddr;
    if (branchQ) eaNext = baseAddr;
    else         eaNext = {baseAddr[ADDR_W-1:OFS_W], baseAddr[OFS_W-1:0] + addQ};
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaOut      <= '0;
      idxWrEn    <= 1'b0;
      idxWrData  <= '0;
      pageWrEn   <= 1'b0;
      pageWrData <= '0;
    end else begin
      idxWrEn  <= stb.finish && wbQ;
      pageWrEn <= stb.finish && branchQ;
      if (stb.finish) begin
        eaOut     <= eaNext;
        idxWrData <= adjQ;
        if (branchQ) pageWrData <= baseAddr[ADDR_W-1:OFS_W];
      end
    end
  end

endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
  import peau_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 13,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startReq,
  input  logic [ADDR_W:0]         addrField,
  input  logic                    isBranch,
  input  logic [DATA_W-1:0]       idxIn,
  input  logic [ADDR_W-OFS_W-1:0] pageIn,
  output logic                    busy,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memAck,
  input  logic [DATA_W-1:0]       memData,
  output logic                    eaValid,
  output logic [ADDR_W-1:0]       eaOut,
  output logic                    idxWrEn,
  output logic [DATA_W-1:0]       idxWrData,
  output logic                    pageWrEn,
  output logic [ADDR_W-OFS_W-1:0] pageWrData
);

  eaStrobe_t stb;

  peau_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .wantIndirect (addrField[ADDR_W]),
    .memAck       (memAck),
    .stb          (stb),
    .memReq       (memReq),
    .busy         (busy),
    .eaValid      (eaValid)
  );

  peau_dpath #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .addrField  (addrField),
    .isBranch   (isBranch),
    .idxIn      (idxIn),
    .pageIn     (pageIn),
    .memData    (memData),
    .memAddr    (memAddr),
    .eaOut      (eaOut),
    .idxWrEn    (idxWrEn),
    .idxWrData  (idxWrData),
    .pageWrEn   (pageWrEn),
    .pageWrData (pageWrData)
  );

endmodule

// File: rtl/peau_checker.sv
module peau_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              eaValid,
  input logic              idxWrEn,
  input logic              pageWrEn
);

  // tracks which pointer byte the next acknowledge delivers
  logic loPhase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 loPhase <= 1'b0;
    else if (eaValid)          loPhase <= 1'b0;
    else if (memReq && memAck) loPhase <= !loPhase;
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |=> !eaValid);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  p_lo_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !loPhase) |=> (memReq && memAddr == $past(memAddr) + ADDR_W'(1)));

  p_idx_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    idxWrEn |-> (eaValid && !pageWrEn));

  p_page_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    pageWrEn |-> eaValid);

  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

bind paged_ea_unit peau_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busy     (busy),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memAck   (memAck),
  .eaValid  (eaValid),
  .idxWrEn  (idxWrEn),
  .pageWrEn (pageWrEn)
);

// File: tb/paged_ea_unit_test.sv
module paged_ea_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] addrField = '0;
  logic        isBranch = 1'b0;
  logic [7:0]  idxIn = '0;
  logic [1:0]  pageIn = '0;
  logic        busy, memReq, eaValid, idxWrEn, pageWrEn;
  logic [14:0] memAddr, eaOut;
  logic        memAck = 1'b0;
  logic [7:0]  memData = '0;
  logic [7:0]  idxWrData;
  logic [1:0]  pageWrData;

  int errors = 0;
  int checks = 0;
  int rdTotal = 0;
  logic [14:0] rdLog [0:3];

  always #5 clk = ~clk;

  paged_ea_unit uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .addrField(addrField),
    .isBranch(isBranch), .idxIn(idxIn), .pageIn(pageIn), .busy(busy),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .eaValid(eaValid), .eaOut(eaOut), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .pageWrEn(pageWrEn), .pageWrData(pageWrData)
  );

  function automatic logic [7:0] memFn(input logic [14:0] a);
    return a[7:0] ^ (a[14:8] * 8'd29) ^ 8'h5A;
  endfunction

  // memory model: acknowledges after a random delay
  always @(negedge clk) begin
    if (memReq && ($urandom_range(0, 1) == 1)) begin
      memAck  <= 1'b1;
      memData <= memFn(memAddr);
      rdLog[rdTotal[1:0]] <= memAddr;
      rdTotal <= rdTotal + 1;
    end else begin
      memAck  <= 1'b0;
      memData <= 8'($urandom);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [15:0] f, input bit br, input logic [7:0] idx,
                       input logic [1:0] pg, input bit disturb);
    logic [14:0] loc, base, expEa;
    logic [1:0]  mode;
    logic [7:0]  adj, addv, hi, lo;
    bit          ind, expIdxEn;
    int          rd0, cyc;
    bit          seen;
    ind  = f[15];
    mode = f[14:13];
    loc  = br ? f[14:0] : {pg, f[12:0]};
    adj  = (mode == 2'b01) ? idx + 8'd1 : (mode == 2'b10) ? idx - 8'd1 : idx;
    addv = (mode == 2'b00) ? 8'd0 : adj;
    hi   = memFn(loc);
    lo   = memFn(loc + 15'd1);
    base = ind ? {hi[6:0], lo} : loc;
    expEa = br ? base : {base[14:13], base[12:0] + 13'(addv)};
    expIdxEn = !br && (mode == 2'b01 || mode == 2'b10);

    @(negedge clk);
    rd0 = rdTotal;
    addrField = f; isBranch = br; idxIn = idx; pageIn = pg; startReq = 1'b1;
    cyc = 0; seen = 0;
    while (!seen && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(busy === 1'b1, "R8", "busy after accept", 32'(busy), 1);
      if (disturb) begin
        addrField = 16'($urandom); isBranch = ~br; idxIn = ~idx; pageIn = ~pg;
      end else begin
        startReq = 1'b0;
      end
      if (eaValid) seen = 1;
      else chk(!idxWrEn && !pageWrEn, "R3", "strobe outside valid",
               {30'd0, idxWrEn, pageWrEn}, 0);
    end
    startReq = 1'b0;
    if (!seen) begin
      chk(1'b0, "R8", "watchdog no eaValid", 32'(cyc), 0);
      return;
    end
    chk(eaOut === expEa, ind ? "R7" : (br ? "R4" : "R2"), "eaOut", 32'(eaOut), 32'(expEa));
    chk(idxWrEn === expIdxEn, "R3", "idxWrEn", 32'(idxWrEn), 32'(expIdxEn));
    if (expIdxEn) chk(idxWrData === adj, "R3", "idxWrData", 32'(idxWrData), 32'(adj));
    chk(pageWrEn === br, br ? "R4" : "R5", "pageWrEn", 32'(pageWrEn), 32'(br));
    if (br) chk(pageWrData === base[14:13], ind ? "R7" : "R4", "pageWrData",
                32'(pageWrData), 32'(base[14:13]));
    if (ind) begin
      chk(rdTotal - rd0 == 2, "R6", "read count", 32'(rdTotal - rd0), 2);
      chk(rdLog[rd0[1:0]] === loc, "R6", "high byte addr", 32'(rdLog[rd0[1:0]]), 32'(loc));
      chk(rdLog[2'(rd0 + 1)] === loc + 15'd1, "R6", "low byte addr",
          32'(rdLog[2'(rd0 + 1)]), 32'(loc + 15'd1));
    end else begin
      chk(rdTotal == rd0, "R9", "no reads when direct", 32'(rdTotal - rd0), 0);
      chk(cyc == 2, "R8", "direct latency", 32'(cyc), 2);
    end
    @(negedge clk);
    chk(!eaValid, "R8", "single-cycle eaValid", 32'(eaValid), 0);
  endtask

  initial begin
    #1500us;
    errors++;
    checks++;
    $display("FAIL R8 global watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2650));
    repeat (3) @(negedge clk);
    chk(!busy && !eaValid && !memReq && !idxWrEn && !pageWrEn && eaOut == 0,
        "R1", "reset outputs", {27'd0, busy, eaValid, memReq, idxWrEn, pageWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!memReq, "R9", "idle memReq", 32'(memReq), 0);

    // directed corners
    runOp(16'h1FFF, 0, 8'h05, 2'b10, 0);             // R2 mode 00, no add
    runOp(16'h3FF0, 0, 8'h20, 2'b01, 0);             // R2 R3 inc, wrap in page
    runOp(16'h2000, 0, 8'hFF, 2'b11, 0);             // R3 inc FF -> 00
    runOp(16'h4010, 0, 8'h00, 2'b00, 0);             // R3 dec 00 -> FF
    runOp(16'h7FFF, 0, 8'h01, 2'b11, 0);             // R3 plain index carry out of page
    runOp(16'h5ABC, 1, 8'h77, 2'b00, 0);             // R4 direct branch
    runOp(16'hFFFF, 1, 8'h00, 2'b01, 0);             // R6 R7 pointer read wraps
    runOp(16'hE123, 0, 8'hF0, 2'b11, 0);             // R7 post-index indirect
    runOp(16'h8050, 0, 8'h10, 2'b00, 1);             // R8 operands ignored while busy
    runOp(16'h0004, 1, 8'h10, 2'b11, 1);             // R8 direct with disturbance

    for (int i = 0; i < 400; i++)
      runOp(16'($urandom), 1'($urandom), 8'($urandom), 2'($urandom), 1'($urandom_range(0, 7) == 0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule